// File: doc/BRIEF.md
# Credit-Gated Virtual Output Queue Grant Arbiter

This block is the central scheduler that lets ingress fabric interfaces send unicast frames toward egress destinations. Every destination keeps a fixed pool of credit tokens. An ingress port asks for a slot by holding a request that carries a destination number and a priority class. For each destination, the arbiter picks at most one requester per cycle and returns a registered grant that names the port and the class. Each grant uses up one token of that destination.

A token comes back only when the egress side reports that the frame has been delivered onward. While a destination raises backpressure, its delivery reports are parked and the tokens stay occupied. The parked reports are released into the pool in the first cycle without backpressure. When a destination has no token left, every port still asking for it is told to drop new arrivals for that queue.

Two instances can run side by side. Both see all requests and returns and keep identical state, but only the one whose `active` input is high drives grants and drop hints. A switchover therefore continues from consistent token counts and fairness pointers.

Top module: `voq_token_arbiter`

## Requirements
- R1: Out of reset no grant is shown, no drop hint is raised, and every destination holds TOKENS free tokens, so TOKENS back-to-back grants to one destination are possible.
- R2: A request sampled at a clock edge produces its grant in the following cycle. The grant carries the requesting port number and the request's class. At most one grant per destination per cycle.
- R3: Each grant consumes one token of its destination. With no free token, no grant is issued for that destination, and `dropHint` for every port requesting it is high in the same cycle. A destination's free count never exceeds TOKENS.
- R4: A delivery report sampled at an edge without backpressure adds one token. That token can be granted from the next request edge on.
- R5: Delivery reports that arrive while `backPress` of the destination is high are held and add no token. All held reports join the pool at the first edge where `backPress` is low.
- R6: A delivery report that would raise free plus held tokens above TOKENS is ignored.
- R7: Class encoding is 0 = first strict class, 1 = second strict class, 2 = normal class, and 3 = treated as normal. A lower code always wins over a higher one for the same destination.
- R8: Among requesters of the winning class, the winner is the first eligible port after the last port granted for that destination, searching upward and wrapping around. The search starts at port 0 after reset.
- R9: With `active` low, no grant and no drop hint are shown, yet tokens and fairness pointers update exactly as if active. After `active` rises, the consumed tokens are still missing.
- R10: A port granted at an edge is not eligible at the next edge. A port holding a request to a destination with credit gets a grant every second cycle.
- R11: Destinations are scheduled independently. Grants to different destinations may appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| active | input | 1 | High when this instance may show grants and drop hints |
| reqValid | input | NUM_PORTS | Per-port request, held as a level |
| reqDest | input | NUM_PORTS*DEST_W | Destination number per port (port p in bits p*DEST_W upward) |
| reqClass | input | 2*NUM_PORTS | Class code per port (port p in bits 2p+1:2p) |
| retValid | input | NUM_DEST | Per-destination delivery report, one token per asserted cycle |
| backPress | input | NUM_DEST | Per-destination egress backpressure |
| grantValid | output | NUM_DEST | Grant issued for the destination this cycle |
| grantPort | output | NUM_DEST*PORT_W | Granted port per destination |
| grantClass | output | 2*NUM_DEST | Class of the granted request per destination |
| dropHint | output | NUM_PORTS | Port's requested destination has no free token |

## Verification
A grant shows up one clock edge after the request is sampled. The bench drives requests at the falling edge and reads grants just after the next rising edge. Drop hints follow requests and token state combinationally, so they are read before that rising edge, in the same cycle as the request. A delivery report or a backpressure release changes the free count at the edge where it is sampled, so its effect is checked by a request in the following cycle. The class order, the fairness rotation and the every-second-cycle pattern of a held request are each followed edge by edge against the expected port sequence.

// File: rtl/voq_arb_pkg.sv
package voq_arb_pkg;

  typedef enum logic [1:0] {
    CLS_HI   = 2'd0,
    CLS_MID  = 2'd1,
    CLS_NORM = 2'd2,
    CLS_RSVD = 2'd3
  } cls_e;

  // strobes from control to datapath, one per destination
  typedef struct packed {
    logic take;
    cls_e cls;
  } pick_s;

  function automatic cls_e normCls(input logic [1:0] raw);
    return (raw == 2'd3) ? CLS_NORM : cls_e'(raw);
  endfunction

endpackage

// File: rtl/voq_rr_pick.sv
module voq_rr_pick
  import voq_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  eligHi,
  input  logic [N-1:0]  eligMid,
  input  logic [N-1:0]  eligLo,
  input  logic [PW-1:0] ptr,
  input  logic          credit,
  output pick_s         pick,
  output logic [PW-1:0] winPort
);

  logic [N-1:0] sel;
  cls_e         selCls;
  logic         found;

  always_comb begin
    if (|eligHi) begin
      sel    = eligHi;
      selCls = CLS_HI;
    end else if (|eligMid) begin
      sel    = eligMid;
      selCls = CLS_MID;
    end else begin
      sel    = eligLo;
      selCls = CLS_NORM;
    end
  end

  always_comb begin
    found   = 1'b0;
    winPort = '0;
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = (int'(ptr) + i) % N;
      if (!found && sel[idx]) begin
        found   = 1'b1;
        winPort = PW'(idx);
      end
    end
    pick.take = found & credit;
    pick.cls  = selCls;
  end

endmodule

// File: rtl/voq_arb_ctrl.sv
module voq_arb_ctrl
  import voq_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int DW = 2,
  parameter int PW = 2,
  parameter int TW = 3
) (
  input  logic [N-1:0]          reqValid,
  input  logic [N*DW-1:0]       reqDest,
  input  logic [2*N-1:0]        reqClass,
  input  logic [N-1:0]          holdMask,
  input  logic [M-1:0][TW-1:0]  freeCnt,
  input  logic [M-1:0][PW-1:0]  rrPtr,
  output pick_s [M-1:0]         picks,
  output logic [M-1:0][PW-1:0]  winPort,
  output logic [N-1:0]          noCredit
);

  logic [M-1:0][N-1:0] eHi, eMid, eLo;

  always_comb begin
    eHi      = '0;
    eMid     = '0;
    eLo      = '0;
    noCredit = '0;
    for (int p = 0; p < N; p++) begin
      logic [DW-1:0] dst;
      cls_e          c;
      dst = reqDest[p*DW +: DW];
      c   = normCls(reqClass[2*p +: 2]);
      if (reqValid[p]) begin
        noCredit[p] = (freeCnt[dst] == '0);
        if (!holdMask[p]) begin
          case (c)
            CLS_HI:  eHi[dst][p]  = 1'b1;
            CLS_MID: eMid[dst][p] = 1'b1;
            default: eLo[dst][p]  = 1'b1;
          endcase
        end
      end
    end
  end

  for (genvar d = 0; d < M; d++) begin : g_pick
    voq_rr_pick #(.N(N), .PW(PW)) u_pick (
      .eligHi (eHi[d]),
      .eligMid(eMid[d]),
      .eligLo (eLo[d]),
      .ptr    (rrPtr[d]),
      .credit (freeCnt[d] != '0),
      .pick   (picks[d]),
      .winPort(winPort[d])
    );
  end

endmodule

// File: rtl/voq_arb_dp.sv
module voq_arb_dp
  import voq_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int PW = 2,
  parameter int TW = 3,
  parameter int T  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pick_s [M-1:0]         picks,
  input  logic [M-1:0][PW-1:0]  winPort,
  input  logic [M-1:0]          retValid,
  input  logic [M-1:0]          backPress,
  output logic [M-1:0][TW-1:0]  freeCnt,
  output logic [M-1:0][PW-1:0]  rrPtr,
  output logic [N-1:0]          holdMask,
  output pick_s [M-1:0]         grantQ,
  output logic [M-1:0][PW-1:0]  grantPortQ
);

  for (genvar d = 0; d < M; d++) begin : g_dest
    logic [TW-1:0] freeQ, pendQ;
    logic [PW-1:0] ptrQ, portQ;
    pick_s         gq;
    logic [TW:0]   inPool, freeNext;
    logic          accept;

    always_comb begin
      inPool   = {1'b0, freeQ} + {1'b0, pendQ};
      accept   = retValid[d] && (inPool < (TW+1)'(T));
      freeNext = {1'b0, freeQ} - {{TW{1'b0}}, picks[d].take};
      if (!backPress[d]) begin
        freeNext = freeNext + {1'b0, pendQ} + {{TW{1'b0}}, accept};
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        freeQ <= TW'(T);
        pendQ <= '0;
        ptrQ  <= PW'(N-1);
        portQ <= '0;
        gq    <= '0;
      end else begin
        freeQ <= freeNext[TW-1:0];
        if (backPress[d]) pendQ <= pendQ + TW'(accept);
        else              pendQ <= '0;
        if (picks[d].take) ptrQ <= winPort[d];
        portQ <= winPort[d];
        gq    <= picks[d];
      end
    end

    assign freeCnt[d]    = freeQ;
    assign rrPtr[d]      = ptrQ;
    assign grantQ[d]     = gq;
    assign grantPortQ[d] = portQ;
  end

  logic [N-1:0] maskNext;

  always_comb begin
    maskNext = '0;
    for (int d = 0; d < M; d++) begin
      if (picks[d].take) maskNext[winPort[d]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdMask <= '0;
    else       holdMask <= maskNext;
  end

endmodule

// File: rtl/voq_token_arbiter.sv
module voq_token_arbiter
  import voq_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_DEST  = 4,
  parameter int TOKENS    = 4,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int TOK_W    = $clog2(TOKENS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        active,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [NUM_PORTS*DEST_W-1:0] reqDest,
  input  logic [2*NUM_PORTS-1:0]      reqClass,
  input  logic [NUM_DEST-1:0]         retValid,
  input  logic [NUM_DEST-1:0]         backPress,
  output logic [NUM_DEST-1:0]         grantValid,
  output logic [NUM_DEST*PORT_W-1:0]  grantPort,
  output logic [2*NUM_DEST-1:0]       grantClass,
  output logic [NUM_PORTS-1:0]        dropHint
);

  pick_s [NUM_DEST-1:0]              picks;
  pick_s [NUM_DEST-1:0]              grantQ;
  logic  [NUM_DEST-1:0][PORT_W-1:0]  winPort;
  logic  [NUM_DEST-1:0][PORT_W-1:0]  grantPortQ;
  logic  [NUM_DEST-1:0][TOK_W-1:0]   freeCnt;
  logic  [NUM_DEST-1:0][PORT_W-1:0]  rrPtr;
  logic  [NUM_PORTS-1:0]             holdMask;
  logic  [NUM_PORTS-1:0]             noCredit;

  voq_arb_ctrl #(
    .N(NUM_PORTS), .M(NUM_DEST), .DW(DEST_W), .PW(PORT_W), .TW(TOK_W)
  ) u_ctrl (
    .reqValid(reqValid),
    .reqDest (reqDest),
    .reqClass(reqClass),
    .holdMask(holdMask),
    .freeCnt (freeCnt),
    .rrPtr   (rrPtr),
    .picks   (picks),
    .winPort (winPort),
    .noCredit(noCredit)
  );

  voq_arb_dp #(
    .N(NUM_PORTS), .M(NUM_DEST), .PW(PORT_W), .TW(TOK_W), .T(TOKENS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .picks     (picks),
    .winPort   (winPort),
    .retValid  (retValid),
    .backPress (backPress),
    .freeCnt   (freeCnt),
    .rrPtr     (rrPtr),
    .holdMask  (holdMask),
    .grantQ    (grantQ),
    .grantPortQ(grantPortQ)
  );

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_out
    assign grantValid[d]                 = grantQ[d].take & active;
    assign grantPort[d*PORT_W +: PORT_W] = grantPortQ[d];
    assign grantClass[2*d +: 2]          = grantQ[d].cls;
  end

  assign dropHint = noCredit & {NUM_PORTS{active}};

endmodule

// File: rtl/voq_arb_chk.sv
module voq_arb_chk
  import voq_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int T  = 4,
  parameter int DW = 2,
  parameter int PW = 2,
  parameter int TW = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 active,
  input logic [N-1:0]         reqValid,
  input logic [N*DW-1:0]      reqDest,
  input logic [2*N-1:0]       reqClass,
  input logic [M-1:0]         backPress,
  input logic [M-1:0]         grantValid,
  input logic [M*PW-1:0]      grantPort,
  input logic [2*M-1:0]       grantClass,
  input logic [N-1:0]         dropHint,
  input logic [M-1:0][TW-1:0] freeCnt
);

  logic [N-1:0]    prevValid;
  logic [N*DW-1:0] prevDest;
  logic [2*N-1:0]  prevClass;
  logic            prevActive;
  logic [N-1:0]    prevGrantMask;
  logic [N-1:0]    curGrantMask;

  always_comb begin
    curGrantMask = '0;
    for (int d = 0; d < M; d++) begin
      if (grantValid[d]) curGrantMask[grantPort[d*PW +: PW]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid     <= '0;
      prevDest      <= '0;
      prevClass     <= '0;
      prevActive    <= 1'b0;
      prevGrantMask <= '0;
    end else begin
      prevValid     <= reqValid;
      prevDest      <= reqDest;
      prevClass     <= reqClass;
      prevActive    <= active;
      prevGrantMask <= curGrantMask;
    end
  end

  assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (grantValid == '0 && dropHint == '0));

  for (genvar d = 0; d < M; d++) begin : g_chk
    logic [PW-1:0] gp;
    logic          stricterSkipped;
    assign gp = grantPort[d*PW +: PW];

    always_comb begin
      stricterSkipped = 1'b0;
      for (int p = 0; p < N; p++) begin
        if (prevValid[p] && prevDest[p*DW +: DW] == DW'(d) && !prevGrantMask[p] &&
            normCls(prevClass[2*p +: 2]) < cls_e'(grantClass[2*d +: 2]))
          stricterSkipped = 1'b1;
      end
    end

    assert_tok_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
      freeCnt[d] <= TW'(T));

    assert_grant_credit_R3: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[d] |-> $past(freeCnt[d]) != '0);

    assert_grant_source_R2: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[d] |-> (prevValid[gp] && prevDest[gp*DW +: DW] == DW'(d) &&
                         normCls(prevClass[2*gp +: 2]) == cls_e'(grantClass[2*d +: 2])));

    assert_bp_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      backPress[d] |=> freeCnt[d] <= $past(freeCnt[d]));

    assert_class_order_R7: assert property (@(posedge clk) disable iff (!rstN)
      (grantValid[d] && prevActive) |-> !stricterSkipped);
  end

endmodule

bind voq_token_arbiter voq_arb_chk #(
  .N(NUM_PORTS), .M(NUM_DEST), .T(TOKENS), .DW(DEST_W), .PW(PORT_W), .TW(TOK_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .active    (active),
  .reqValid  (reqValid),
  .reqDest   (reqDest),
  .reqClass  (reqClass),
  .backPress (backPress),
  .grantValid(grantValid),
  .grantPort (grantPort),
  .grantClass(grantClass),
  .dropHint  (dropHint),
  .freeCnt   (freeCnt)
);

// File: tb/voq_token_arbiter_tb.sv
`timescale 1ns/1ps
module voq_token_arbiter_tb;
  localparam int N = 4, M = 4, T = 4, DW = 2, PW = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          active;
  logic [N-1:0]  reqValid;
  logic [N*DW-1:0] reqDest;
  logic [2*N-1:0]  reqClass;
  logic [M-1:0]  retValid, backPress;
  logic [M-1:0]  grantValid;
  logic [M*PW-1:0] grantPort;
  logic [2*M-1:0]  grantClass;
  logic [N-1:0]  dropHint;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  voq_token_arbiter #(.NUM_PORTS(N), .NUM_DEST(M), .TOKENS(T)) u_dut (
    .clk(clk), .rstN(rstN), .active(active), .reqValid(reqValid),
    .reqDest(reqDest), .reqClass(reqClass), .retValid(retValid),
    .backPress(backPress), .grantValid(grantValid), .grantPort(grantPort),
    .grantClass(grantClass), .dropHint(dropHint)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setReq(input int p, input int d, input int c);
    reqValid[p]          = 1'b1;
    reqDest[p*DW +: DW]  = DW'(d);
    reqClass[2*p +: 2]   = 2'(c);
  endtask

  task automatic clrReq(input int p);
    reqValid[p] = 1'b0;
  endtask

  // single-cycle request; checks drop hint in the request cycle and grant after the edge
  task automatic oneReq(input int p, input int d, input int c, input bit expGrant,
                        input bit expDrop, input string tag);
    @(negedge clk);
    setReq(p, d, c);
    #1;
    checkEq({tag, " drop"}, int'(dropHint[p]), int'(expDrop));
    @(posedge clk); #1;
    checkEq({tag, " grant"}, int'(grantValid[d]), int'(expGrant));
    if (expGrant) begin
      checkEq({tag, " port"}, int'(grantPort[d*PW +: PW]), p);
      checkEq({tag, " class"}, int'(grantClass[2*d +: 2]), c);
    end
    @(negedge clk);
    clrReq(p);
  endtask

  task automatic giveBack(input int d, input int k);
    @(negedge clk);
    retValid[d] = 1'b1;
    repeat (k) @(negedge clk);
    retValid[d] = 1'b0;
  endtask

  task automatic finishRun;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic testReset;
    @(posedge clk); #1;
    checkEq("R1 no grant after reset", int'(grantValid), 0);
    checkEq("R1 no drop after reset", int'(dropHint), 0);
    for (int i = 0; i < T; i++) oneReq(0, 0, 2, 1'b1, 1'b0, "R1 full pool grant");
    oneReq(0, 0, 2, 1'b0, 1'b1, "R3 exhausted no grant");
  endtask

  task automatic testReturn;
    giveBack(0, 1);
    oneReq(0, 0, 2, 1'b1, 1'b0, "R4 returned token granted");
    oneReq(0, 0, 2, 1'b0, 1'b1, "R4 only one token back");
    giveBack(0, T);
  endtask

  task automatic testBackpressure;
    for (int i = 0; i < T; i++) oneReq(1, 1, 2, 1'b1, 1'b0, "R3 consume dest1");
    @(negedge clk);
    backPress[1] = 1'b1;
    giveBack(1, 2);
    oneReq(1, 1, 2, 1'b0, 1'b1, "R5 held under backpressure");
    @(negedge clk);
    backPress[1] = 1'b0;
    @(negedge clk);
    oneReq(1, 1, 2, 1'b1, 1'b0, "R5 released first");
    oneReq(1, 1, 2, 1'b1, 1'b0, "R5 released second");
    oneReq(1, 1, 2, 1'b0, 1'b1, "R5 only held tokens released");
    giveBack(1, T);
  endtask

  task automatic testOverflow;
    giveBack(2, 2);
    for (int i = 0; i < T; i++) oneReq(2, 2, 2, 1'b1, 1'b0, "R6 pool stays at limit");
    oneReq(2, 2, 2, 1'b0, 1'b1, "R6 extra return ignored");
    giveBack(2, T);
  endtask

  task automatic testPriority;
    @(negedge clk);
    setReq(0, 3, 2); setReq(1, 3, 1); setReq(2, 3, 0);
    @(posedge clk); #1;
    checkEq("R7 first strict wins", int'(grantPort[3*PW +: PW]), 2);
    checkEq("R7 first strict class", int'(grantClass[7:6]), 0);
    @(negedge clk);
    clrReq(2);
    @(posedge clk); #1;
    checkEq("R7 second strict next", int'(grantPort[3*PW +: PW]), 1);
    checkEq("R7 second strict class", int'(grantClass[7:6]), 1);
    @(posedge clk); #1;
    checkEq("R10 masked port skipped, normal wins", int'(grantPort[3*PW +: PW]), 0);
    checkEq("R10 normal grant valid", int'(grantValid[3]), 1);
    @(negedge clk);
    clrReq(0); clrReq(1);
    giveBack(3, 3);
  endtask

  task automatic testRoundRobin;
    int last = 0;
    for (int r = 0; r < 5; r++) begin
      int exp;
      exp = (last + 1) % N;
      @(negedge clk);
      for (int p = 0; p < N; p++) setReq(p, 0, 2);
      @(posedge clk); #1;
      checkEq("R8 rotation valid", int'(grantValid[0]), 1);
      checkEq("R8 rotation port", int'(grantPort[0 +: PW]), exp);
      @(negedge clk);
      for (int p = 0; p < N; p++) clrReq(p);
      last = exp;
      giveBack(0, 1);
    end
  endtask

  task automatic testParallel;
    @(negedge clk);
    for (int p = 0; p < N; p++) setReq(p, p, 2);
    @(posedge clk); #1;
    checkEq("R11 all destinations granted", int'(grantValid), 15);
    for (int d = 0; d < M; d++)
      checkEq("R11 per-destination port", int'(grantPort[d*PW +: PW]), d);
    @(negedge clk);
    for (int p = 0; p < N; p++) clrReq(p);
    for (int d = 0; d < M; d++) giveBack(d, 1);
  endtask

  task automatic testHold;
    @(negedge clk);
    setReq(1, 1, 2);
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      checkEq("R10 held request alternates", int'(grantValid[1]), (c % 2 == 0) ? 1 : 0);
    end
    @(negedge clk);
    clrReq(1);
    giveBack(1, 2);
  endtask

  task automatic testStandby;
    @(negedge clk);
    active = 1'b0;
    for (int i = 0; i < T; i++) oneReq(2, 2, 2, 1'b0, 1'b0, "R9 standby hides grant");
    oneReq(2, 2, 2, 1'b0, 1'b0, "R9 standby hides drop");
    @(negedge clk);
    active = 1'b1;
    oneReq(2, 2, 2, 1'b0, 1'b1, "R9 tokens consumed in standby");
    giveBack(2, 1);
    oneReq(2, 2, 2, 1'b1, 1'b0, "R9 active grants after return");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; active = 1'b1;
    reqValid = '0; reqDest = '0; reqClass = '0;
    retValid = '0; backPress = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReturn();
    testBackpressure();
    testOverflow();
    testPriority();
    testRoundRobin();
    testParallel();
    testHold();
    testStandby();
    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule